// File: doc/BRIEF.md
# One-Shot Event Timer with Timestamp

This peripheral sits on a simple single-cycle register bus. It holds two counters that share one register window. The first is a free-running timestamp that counts up by one on every timer tick and wraps. The second is an event counter. Software loads it with a number of ticks and then enables it. The counter counts down, and when it runs out the block sets a terminal-count flag in its control/status byte and drives a level interrupt high. The interrupt stays high until software writes the flag bit back as one.

The tick is a one-clock pulse. It is made inside the block by dividing the bus clock by `CLK_HZ/TICK_HZ`, which gives a 1 MHz tick with the default parameters. Programmed counts are meant to lie between 0xF and 0xFFFFFFFF ticks. To arm the timer, software writes the flag bit alone, then the count, then the flag bit together with enable. Two mode bits change what happens at expiry. With periodic and reload both set, the counter restarts from the last written count. With periodic set and reload clear, the counter wraps to all ones and keeps counting down. With periodic clear, the block runs one shot and drops enable by itself.

Top module: `evt_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every counter, mode bit and the flag go to zero, and so do `irq` and `bus_rdata`.
- R2: The timestamp (offset 0x08) advances by exactly one on each tick, one tick every `CLK_HZ/TICK_HZ` clocks, and wraps to zero after its all-ones value (width `STAMP_W`, zero-extended on read).
- R3: A read (`bus_sel`=1, `bus_wr`=0) returns its data on `bus_rdata` in the cycle after the request. The data is the count at offset 0x00, the timestamp at 0x08, or the control byte at 0x14 (bit 0 enable, bit 1 periodic, bit 2 reload, bit 7 flag, other bits zero). Any other offset reads zero, and `bus_rdata` is zero in cycles with no read.
- R4: A write to offset 0x00 loads both the event counter and the stored reload value. This write takes priority over a decrement in the same cycle.
- R5: While enabled, the event counter drops by one on each tick. While disabled, it holds its value.
- R6: A tick that finds the enabled counter at 1 or 0 is an expiry. It sets the flag and raises `irq`. In one-shot mode (periodic=0) the expiry also clears enable and leaves the counter at zero.
- R7: Writing the control byte with bit 7 = 1 clears the flag and `irq`, and writing bit 7 = 0 leaves the flag alone. If an expiry falls in the same cycle as a clear, the flag stays set.
- R8: Writing the control byte with only bit 7 set stops the counter, so the count is frozen.
- R9: With periodic=1 and reload=1, an expiry reloads the last count written and enable stays set.
- R10: With periodic=1 and reload=0, an expiry wraps the counter to all ones and it keeps counting down.
- R11: Writes to the timestamp offset and to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, equal to the terminal-count flag |

## Verification
The bench targets the collision between a flag clear and an expiry on the same tick edge. A design that let the clear win would lose an event, and `irq` would stay low after that edge. It measures a timestamp wrap over exactly 2^STAMP_W ticks, so an off-by-one in the wrap or the divider shows up as unequal readings. It also checks the three expiry modes. A wrong priority would leave enable set after a one-shot, reload zero instead of the stored count, or stop instead of wrapping. Writes to read-only and unmapped offsets are followed by readback, so a loose address decode that corrupts the timestamp or the control byte is caught.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Byte offsets inside the register window
  localparam int OFS_COUNT = 'h00;
  localparam int OFS_STAMP = 'h08;
  localparam int OFS_CTRL  = 'h14;

  // Control/status byte bit positions
  localparam int CB_EN  = 0;
  localparam int CB_PER = 1;
  localparam int CB_RLD = 2;
  localparam int CB_TC  = 7;

  typedef struct packed {
    logic tc;
    logic rld;
    logic per;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_STAMP,
    SEL_CTRL
  } reg_sel_e;

endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;

      assign tick_o = (div_q == DW'(TICK_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst || tick_o) div_q <= '0;
        else               div_q <= div_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/evt_stamp_ctr.sv
module evt_stamp_ctr #(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [STAMP_W-1:0] stamp_o
);

  logic [STAMP_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst)       stamp_q <= '0;
    else if (tick) stamp_q <= stamp_q + 1'b1;
  end

  assign stamp_o = stamp_q;

endmodule

// File: rtl/evt_oneshot.sv
module evt_oneshot
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] rld_q;
  ctrl_t             ctrl_q;
  logic              expire;
  logic [DATA_W-1:0] restart_val;

  // Expiry: an enabled tick that finds the counter at its last step
  assign expire = ctrl_q.en && tick && !wr_cnt && (cnt_q <= DATA_W'(1));

  // Value the counter takes at expiry, chosen by the mode bits
  always_comb begin
    if (!ctrl_q.per)     restart_val = '0;
    else if (ctrl_q.rld) restart_val = rld_q;
    else                 restart_val = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
      rld_q <= wdata;
    end else if (ctrl_q.en && tick) begin
      cnt_q <= expire ? restart_val : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctrl_q.en  <= wdata[CB_EN];
        ctrl_q.per <= wdata[CB_PER];
        ctrl_q.rld <= wdata[CB_RLD];
      end else if (expire && !ctrl_q.per) begin
        ctrl_q.en <= 1'b0;
      end
      // A new expiry outranks a clear in the same cycle
      if (expire)                    ctrl_q.tc <= 1'b1;
      else if (wr_ctl && wdata[CB_TC]) ctrl_q.tc <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = ctrl_q.tc;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int STAMP_W = 32,
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int TICK_DIV = CLK_HZ / TICK_HZ;

  logic               tick;
  logic [STAMP_W-1:0] stamp;
  logic [DATA_W-1:0]  evt_cnt;
  ctrl_t              evt_ctrl;
  logic               evt_irq;
  reg_sel_e           sel_d;
  logic               wr_cnt;
  logic               wr_ctl;
  logic               rd_en;
  logic               rd_unmapped;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;

  // Address decode
  always_comb begin
    if (bus_addr == ADDR_W'(OFS_COUNT))      sel_d = SEL_COUNT;
    else if (bus_addr == ADDR_W'(OFS_STAMP)) sel_d = SEL_STAMP;
    else if (bus_addr == ADDR_W'(OFS_CTRL))  sel_d = SEL_CTRL;
    else                                     sel_d = SEL_NONE;
  end

  assign wr_cnt      = bus_sel && bus_wr && (sel_d == SEL_COUNT);
  assign wr_ctl      = bus_sel && bus_wr && (sel_d == SEL_CTRL);
  assign rd_en       = bus_sel && !bus_wr;
  assign rd_unmapped = (sel_d == SEL_NONE);

  evt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  evt_stamp_ctr #(.STAMP_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .stamp_o (stamp)
  );

  evt_oneshot #(.DATA_W(DATA_W)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wr_cnt (wr_cnt),
    .wr_ctl (wr_ctl),
    .wdata  (bus_wdata),
    .cnt_o  (evt_cnt),
    .ctrl_o (evt_ctrl),
    .irq_o  (evt_irq)
  );

  // Read multiplexer
  always_comb begin
    unique case (sel_d)
      SEL_COUNT: rd_mux = evt_cnt;
      SEL_STAMP: rd_mux = DATA_W'(stamp);
      SEL_CTRL:  rd_mux = DATA_W'({evt_ctrl.tc, 4'b0000, evt_ctrl.rld,
                                   evt_ctrl.per, evt_ctrl.en});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
    else            rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign irq       = evt_irq;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic [STAMP_W-1:0] stamp,
  input logic [DATA_W-1:0]  cnt,
  input logic               en,
  input logic               wr_cnt,
  input logic               wr_ctl,
  input logic [DATA_W-1:0]  wdata,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               rd_unmapped,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq
);

  // R2
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> stamp == STAMP_W'($past(stamp) + 1'b1));

  // R2
  stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stamp));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> $stable(cnt));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tick && en));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_ctl && wdata[7]));

  // R3
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && rd_unmapped) |=> rdata == '0);

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !wdata[0]) |=> !en);

endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W), .STAMP_W(STAMP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .stamp       (stamp),
  .cnt         (evt_cnt),
  .en          (evt_ctrl.en),
  .wr_cnt      (wr_cnt),
  .wr_ctl      (wr_ctl),
  .wdata       (bus_wdata),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .rd_unmapped (rd_unmapped),
  .rdata       (bus_rdata),
  .irq         (irq)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;

  localparam int DW   = 32;
  localparam int AW   = 5;
  localparam int SW   = 10;
  localparam int DIV  = 4;
  localparam logic [AW-1:0] A_CNT = 5'h00;
  localparam logic [AW-1:0] A_STP = 5'h08;
  localparam logic [AW-1:0] A_CTL = 5'h14;
  localparam logic [31:0] SMASK = (32'h1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  evt_timer #(.DATA_W(DW), .ADDR_W(AW), .STAMP_W(SW),
              .CLK_HZ(4_000_000), .TICK_HZ(1_000_000)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq));

  // Behavioural reference model
  int          divc = 0;
  logic [31:0] m_stamp = 0, m_cnt = 0, m_rld = 0, m_rdata = 0, m_rv;
  bit          m_en = 0, m_per = 0, m_rl = 0, m_tc = 0;
  bit          m_tk, m_ex, m_wc, m_wt;

  always @(posedge clk) begin
    if (rst) begin
      divc = 0; m_stamp = 0; m_cnt = 0; m_rld = 0; m_rdata = 0;
      m_en = 0; m_per = 0; m_rl = 0; m_tc = 0;
    end else begin
      m_tk = (divc == DIV - 1);
      case (bus_addr)
        A_CNT:   m_rv = m_cnt;
        A_STP:   m_rv = m_stamp;
        A_CTL:   m_rv = {24'h0, m_tc, 4'h0, m_rl, m_per, m_en};
        default: m_rv = 0;
      endcase
      m_rdata = (bus_sel && !bus_wr) ? m_rv : 32'h0;
      m_wc = bus_sel && bus_wr && (bus_addr == A_CNT);
      m_wt = bus_sel && bus_wr && (bus_addr == A_CTL);
      m_ex = m_en && m_tk && !m_wc && (m_cnt <= 1);
      if (m_wc) begin
        m_cnt = bus_wdata; m_rld = bus_wdata;
      end else if (m_en && m_tk) begin
        if (m_ex) m_cnt = !m_per ? 32'h0 : (m_rl ? m_rld : 32'hFFFF_FFFF);
        else      m_cnt = m_cnt - 1;
      end
      if (m_ex)                   m_tc = 1;
      else if (m_wt && bus_wdata[7]) m_tc = 0;
      if (m_wt) begin
        m_en = bus_wdata[0]; m_per = bus_wdata[1]; m_rl = bus_wdata[2];
      end else if (m_ex && !m_per) m_en = 0;
      if (m_tk) m_stamp = (m_stamp + 1) & SMASK;
      divc = m_tk ? 0 : divc + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R6 irq level", {31'h0, irq}, {31'h0, m_tc});
      chk("R3 read data", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    chk(tag, d, m_rdata);
    bus_sel = 0;
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, b;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst = 0;
    rd(A_CTL, "R1 ctrl after reset", d);
    chk("R1 ctrl zero", d, 32'h0);
    rd(A_CNT, "R1 count after reset", d);
    chk("R1 count zero", d, 32'h0);

    // R3: unmapped offsets read zero
    rd(5'h04, "R3 unmapped 0x04", d);
    chk("R3 unmapped zero", d, 32'h0);
    rd(5'h1C, "R3 unmapped 0x1C", d);
    chk("R3 unmapped zero 1C", d, 32'h0);

    // R2: timestamp advance and wrap over exactly 2^SW ticks
    rd(A_STP, "R2 stamp first", a);
    repeat (4094) @(negedge clk);
    rd(A_STP, "R2 stamp after full wrap", b);
    chk("R2 wrap period", b, a);

    // R11: writes to timestamp and unmapped offsets are ignored
    wr(A_STP, 32'h0000_0155);
    rd(A_STP, "R11 stamp unchanged", d);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(A_CTL, "R11 ctrl untouched", d);
    chk("R11 ctrl still zero", d, 32'h0);
    rd(A_CNT, "R11 count untouched", d);
    chk("R11 count still zero", d, 32'h0);

    // R4: count load and readback while disabled
    wr(A_CNT, 32'h1234_5678);
    repeat (9) @(negedge clk);
    rd(A_CNT, "R4 count readback", d);
    chk("R4 loaded value held", d, 32'h1234_5678);

    // R5, R6: one-shot arm sequence
    wr(A_CTL, 32'h80);
    wr(A_CNT, 32'd40);
    wr(A_CTL, 32'h81);
    repeat (10) @(negedge clk);
    rd(A_CNT, "R5 count early", a);
    repeat (12) @(negedge clk);
    rd(A_CNT, "R5 count later", b);
    chk("R5 decreasing", {31'h0, (b < a)}, 32'h1);
    wait_irq(400);
    chk("R6 irq raised", {31'h0, irq}, 32'h1);
    rd(A_CTL, "R6 ctrl after expiry", d);
    chk("R6 flag set, enable cleared", d, 32'h80);
    rd(A_CNT, "R6 count at zero", d);
    chk("R6 count zero", d, 32'h0);

    // R7: writing 0 to flag leaves it, writing 1 clears it
    wr(A_CTL, 32'h00);
    chk("R7 flag kept on zero write", {31'h0, irq}, 32'h1);
    wr(A_CTL, 32'h80);
    chk("R7 flag cleared", {31'h0, irq}, 32'h0);

    // R8: stop by writing flag bit alone
    wr(A_CNT, 32'd100);
    wr(A_CTL, 32'h81);
    repeat (20) @(negedge clk);
    wr(A_CTL, 32'h80);
    rd(A_CNT, "R8 count at stop", a);
    repeat (16) @(negedge clk);
    rd(A_CNT, "R8 count frozen", b);
    chk("R8 no further decrement", b, a);
    rd(A_CTL, "R8 ctrl stopped", d);
    chk("R8 enable clear", d, 32'h0);

    // R9: periodic with reload
    wr(A_CNT, 32'd20);
    wr(A_CTL, 32'h87);
    wait_irq(400);
    chk("R9 first expiry", {31'h0, irq}, 32'h1);
    rd(A_CTL, "R9 ctrl keeps enable", d);
    chk("R9 ctrl value", d, 32'h87);
    wr(A_CTL, 32'h86 | 32'h1);
    rd(A_CNT, "R9 count reloaded", d);
    chk("R9 count near reload", {31'h0, (d <= 32'd20 && d >= 32'd15)}, 32'h1);
    wait_irq(400);
    chk("R9 second expiry", {31'h0, irq}, 32'h1);

    // R7: clear colliding with an expiry (count 1 expires on every tick)
    wr(A_CTL, 32'h80);
    wr(A_CNT, 32'd1);
    wr(A_CTL, 32'h87);
    wait_irq(40);
    @(negedge clk);
    while (divc != DIV - 1) @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = A_CTL; bus_wdata = 32'h87;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    chk("R7 expiry wins over clear", {31'h0, irq}, 32'h1);
    while (divc != 0) @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = A_CTL; bus_wdata = 32'h87;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    chk("R7 clear off tick", {31'h0, irq}, 32'h0);

    // R10: periodic without reload wraps to all ones
    wr(A_CTL, 32'h80);
    wr(A_CNT, 32'd16);
    wr(A_CTL, 32'h83);
    wait_irq(400);
    rd(A_CNT, "R10 count after wrap", d);
    chk("R10 wrapped high", {31'h0, (d > 32'hFFFF_FF00)}, 32'h1);
    rd(A_CTL, "R10 enable kept", d);
    chk("R10 ctrl value", d, 32'h83);
    wr(A_CTL, 32'h80);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule